// File: doc/BRIEF.md
# CAN Nominal Bit Timing Generator

This block turns a fast clock into the nominal bit rhythm of a CAN node. A programmable divider produces time quanta. A state machine then walks each bit through a one-quantum synchronization segment, a first programmable segment and a second programmable segment. The first segment holds both the propagation time and phase 1. The block raises a one-clock sample strobe at the end of the first segment, together with the captured bus level. It raises a one-clock bit-end strobe at the end of the second segment.

All four configuration fields use a stored-plus-one meaning. These are the divider, the two segment lengths and the jump width. For example, a stored first-segment value of 16 gives 17 quanta. The fields are captured only while the block is held in its init state. The frame logic around it reports when the bus is idle. Falling bus edges (recessive 1 to dominant 0) then either restart the bit outright or nudge it within the jump width.

States: `BT_INIT` (held while `init_i` is high; loads configuration), `BT_SYNC` (one quantum), `BT_SEG1`, `BT_SEG2`. Transitions: `init_i` high, from any state to `BT_INIT`. Leaving init: `BT_INIT`→`BT_SYNC`. Quantum done: `BT_SYNC`→`BT_SEG1`. Sample point: `BT_SEG1`→`BT_SEG2`. Bit end, cut or hard sync: `BT_SEG2`→`BT_SYNC`. Hard sync: `BT_SEG1`→`BT_SYNC` and `BT_SYNC`→`BT_SYNC`.

Top module: `can_bit_timer`

## Requirements
- R1: After reset, and in every clock after `init_i` is sampled high, `tq_o`, `sample_o` and `bit_end_o` are 0. After reset `rx_bit_o` is 1.
- R2: One quantum lasts `cfg_presc_i`+1 clocks. `tq_o` pulses for one clock on the last clock of each quantum.
- R3: With no bus edges, a bit lasts 1 + (`cfg_seg1_i`+1) + (`cfg_seg2_i`+1) quanta. `sample_o` is high on the last clock of the first segment. `bit_end_o` is high on the last clock of the bit. With seg1 field 16, seg2 field 5 and divider 0, a bit is 24 clocks and the sample falls on clock 18.
- R4: `sample_o` and `bit_end_o` are never high in the same clock.
- R5: At each sample strobe, `rx_bit_o` takes the bus level that `rx_i` had one clock earlier, and it holds that value until the next strobe (1 recessive, 0 dominant).
- R6: Configuration inputs are captured only in `BT_INIT`; changes while running have no effect. When `init_i` is sampled low, the following clock is the first clock of a synchronization quantum.
- R7: `rx_i` is registered once. A falling edge shows in the clock where the registered level first reads 0. If `bus_idle_i` is high in that clock and the block is not in init, the next clock starts a new synchronization quantum. This hard sync drops any pending sample.
- R8: A falling edge during the first segment, with `bus_idle_i` low, lengthens that segment by min(q+1, `cfg_jump_i`+1) quanta. Here q is the zero-based index of the segment quantum holding the edge. An edge in the sample clock itself is ignored.
- R9: A falling edge during the second segment, with `bus_idle_i` low, is handled by the number r of segment quanta left after its own quantum. If r ≤ `cfg_jump_i`+1, the bit ends in that clock (`bit_end_o` high) and the next clock starts a synchronization quantum. Otherwise the segment is shortened by `cfg_jump_i`+1 quanta.
- R10: At most one resynchronization (R8/R9) is applied between two sample strobes, and a hard sync also counts as one. Rising edges have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Hold in init state and load configuration |
| cfg_presc_i | input | 9 | Quantum divider, stored minus one |
| cfg_seg1_i | input | 8 | First segment length minus one |
| cfg_seg2_i | input | 7 | Second segment length minus one |
| cfg_jump_i | input | 7 | Resynchronization jump width minus one |
| bus_idle_i | input | 1 | Bus idle: falling edges hard-synchronize |
| rx_i | input | 1 | Synchronized bus level, 1 recessive |
| tq_o | output | 1 | Last clock of each quantum |
| sample_o | output | 1 | Sample point strobe |
| rx_bit_o | output | 1 | Bus level captured at the last sample point |
| bit_end_o | output | 1 | End-of-bit strobe |

## Verification
Several properties are checked on every cycle: outputs stay quiet after init is requested, quanta are evenly spaced, the two strobes are exclusive, the captured bit is taken at the sample point and held between strobes, configuration stays frozen outside init, and no more than one phase adjustment happens per sample interval. Only the bench scenarios can show where each strobe lands. These include plain bits at several divider and segment settings, lengthened first segments with and without the jump-width cap, shortened and cut second segments, and hard syncs arriving in either segment, each compared against clock numbers computed from the requirements.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    typedef enum logic [1:0] {
        BT_INIT = 2'd0,
        BT_SYNC = 2'd1,
        BT_SEG1 = 2'd2,
        BT_SEG2 = 2'd3
    } bt_state_e;
endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tq_end_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tq_end_o = (cnt_q == div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (restart_i || tq_end_o)  cnt_q <= '0;
        else                             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cbt_edge_det.sv
module cbt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic rx_q_o,
    output logic fall_o
);
    logic rx_q, rx_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q      <= 1'b1;
            rx_prev_q <= 1'b1;
        end else begin
            rx_q      <= rx_i;
            rx_prev_q <= rx_q;
        end
    end

    assign rx_q_o = rx_q;
    assign fall_o = rx_prev_q & ~rx_q;
endmodule

// File: rtl/cbt_resync_calc.sv
module cbt_resync_calc #(
    parameter int QC_W = 10
) (
    input  logic [QC_W-1:0] qcnt_i,
    input  logic [QC_W-1:0] seg2_last_i,
    input  logic [QC_W-1:0] jump_len_i,
    output logic [QC_W-1:0] ext_amt_o,
    output logic            near_end_o
);
    logic [QC_W-1:0] elapsed;
    logic [QC_W-1:0] remain;

    always_comb begin
        elapsed    = qcnt_i + QC_W'(1);
        ext_amt_o  = (elapsed < jump_len_i) ? elapsed : jump_len_i;
        remain     = seg2_last_i - qcnt_i;
        near_end_o = (remain <= jump_len_i);
    end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import cbt_pkg::*;
#(
    parameter int BRP_W = 9,
    parameter int TS1_W = 8,
    parameter int TS2_W = 7,
    parameter int SJW_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic [BRP_W-1:0] cfg_presc_i,
    input  logic [TS1_W-1:0] cfg_seg1_i,
    input  logic [TS2_W-1:0] cfg_seg2_i,
    input  logic [SJW_W-1:0] cfg_jump_i,
    input  logic             bus_idle_i,
    input  logic             rx_i,
    output logic             tq_o,
    output logic             sample_o,
    output logic             rx_bit_o,
    output logic             bit_end_o
);
    localparam int QC_W = TS1_W + 2;

    bt_state_e state_q, state_d;

    logic [BRP_W-1:0] presc_q;
    logic [TS1_W-1:0] seg1_q;
    logic [TS2_W-1:0] seg2_q;
    logic [SJW_W-1:0] jump_q;

    logic [QC_W-1:0] qcnt_q, ext_q, shr_q;
    logic [QC_W-1:0] seg1_last, seg2_base, seg2_last, jump_len, ext_amt;
    logic            rsync_used_q, rx_bit_q;

    logic tq_end, rx_q, fall, near_end;
    logic seg1_done, seg2_done, hard_sync, rs_ok, ext_go, shr_go, cut, adj, restart;

    assign seg2_base = QC_W'(seg2_q);
    assign jump_len  = QC_W'(jump_q) + QC_W'(1);
    assign seg1_last = QC_W'(seg1_q) + ext_q;
    assign seg2_last = seg2_base - shr_q;

    cbt_prescaler #(.DIV_W(BRP_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .div_i     (presc_q),
        .tq_end_o  (tq_end)
    );

    cbt_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx_i),
        .rx_q_o (rx_q),
        .fall_o (fall)
    );

    cbt_resync_calc #(.QC_W(QC_W)) u_calc (
        .qcnt_i      (qcnt_q),
        .seg2_last_i (seg2_base),
        .jump_len_i  (jump_len),
        .ext_amt_o   (ext_amt),
        .near_end_o  (near_end)
    );

    // Event decode
    always_comb begin
        seg1_done = (state_q == BT_SEG1) && tq_end && (qcnt_q == seg1_last);
        seg2_done = (state_q == BT_SEG2) && tq_end && (qcnt_q == seg2_last);
        hard_sync = fall && bus_idle_i && (state_q != BT_INIT);
        rs_ok     = fall && !bus_idle_i && !rsync_used_q;
        ext_go    = rs_ok && (state_q == BT_SEG1) && !seg1_done;
        cut       = rs_ok && (state_q == BT_SEG2) && near_end;
        shr_go    = rs_ok && (state_q == BT_SEG2) && !near_end && !seg2_done;
        adj       = ext_go || shr_go || cut;
        restart   = (state_q == BT_INIT) || hard_sync || cut;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BT_INIT;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (init_i) begin
            state_d = BT_INIT;
        end else begin
            unique case (state_q)
                BT_INIT: state_d = BT_SYNC;
                BT_SYNC: begin
                    if (hard_sync)   state_d = BT_SYNC;
                    else if (tq_end) state_d = BT_SEG1;
                end
                BT_SEG1: begin
                    if (hard_sync)      state_d = BT_SYNC;
                    else if (seg1_done) state_d = BT_SEG2;
                end
                BT_SEG2: begin
                    if (hard_sync || cut || seg2_done) state_d = BT_SYNC;
                end
                default: state_d = BT_INIT;
            endcase
        end
    end

    // Configuration capture, counters and phase adjustment
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q      <= '0;
            seg1_q       <= '0;
            seg2_q       <= '0;
            jump_q       <= '0;
            qcnt_q       <= '0;
            ext_q        <= '0;
            shr_q        <= '0;
            rsync_used_q <= 1'b0;
            rx_bit_q     <= 1'b1;
        end else begin
            if (state_q == BT_INIT) begin
                presc_q <= cfg_presc_i;
                seg1_q  <= cfg_seg1_i;
                seg2_q  <= cfg_seg2_i;
                jump_q  <= cfg_jump_i;
            end

            if ((state_q == BT_INIT) || (state_d != state_q) || hard_sync || cut)
                qcnt_q <= '0;
            else if (tq_end)
                qcnt_q <= qcnt_q + QC_W'(1);

            if (state_q != BT_SEG1) ext_q <= '0;
            else if (ext_go)        ext_q <= ext_amt;

            if (state_q != BT_SEG2) shr_q <= '0;
            else if (shr_go)        shr_q <= jump_len;

            if (state_q == BT_INIT)     rsync_used_q <= 1'b0;
            else if (hard_sync || adj)  rsync_used_q <= 1'b1;
            else if (seg1_done)         rsync_used_q <= 1'b0;

            if (seg1_done) rx_bit_q <= rx_q;
        end
    end

    // Outputs
    always_comb begin
        tq_o      = tq_end && (state_q != BT_INIT);
        sample_o  = seg1_done;
        bit_end_o = seg2_done || cut;
        rx_bit_o  = rx_bit_q;
    end
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker
    import cbt_pkg::*;
#(
    parameter int BRP_W = 9,
    parameter int TS1_W = 8,
    parameter int TS2_W = 7,
    parameter int SJW_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_i,
    input logic             rx_i,
    input logic             tq_o,
    input logic             sample_o,
    input logic             rx_bit_o,
    input logic             bit_end_o,
    input bt_state_e        state_q,
    input logic [BRP_W-1:0] presc_q,
    input logic [TS1_W-1:0] seg1_q,
    input logic [TS2_W-1:0] seg2_q,
    input logic [SJW_W-1:0] jump_q,
    input logic             restart,
    input logic             adj
);
    logic [BRP_W-1:0] gap_q;
    logic             adj_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                gap_q <= '0;
        else if (restart || tq_o)  gap_q <= '0;
        else                       gap_q <= gap_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  adj_seen_q <= 1'b0;
        else if (state_q == BT_INIT || sample_o)     adj_seen_q <= 1'b0;
        else if (adj)                                adj_seen_q <= 1'b1;
    end

    a_r1_quiet_in_init: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (!tq_o && !sample_o && !bit_end_o));

    a_r2_quantum_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tq_o |-> (gap_q == presc_q));

    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_o, bit_end_o}));

    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> (rx_bit_o == $past(rx_i, 2)));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_o |=> $stable(rx_bit_o));

    a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != BT_INIT) |=> ($stable(presc_q) && $stable(seg1_q) && $stable(seg2_q) && $stable(jump_q)));

    a_r10_single_resync: assert property (@(posedge clk) disable iff (!rst_n)
        adj |-> !adj_seen_q);
endmodule

bind can_bit_timer cbt_checker #(
    .BRP_W(BRP_W), .TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_i    (init_i),
    .rx_i      (rx_i),
    .tq_o      (tq_o),
    .sample_o  (sample_o),
    .rx_bit_o  (rx_bit_o),
    .bit_end_o (bit_end_o),
    .state_q   (state_q),
    .presc_q   (presc_q),
    .seg1_q    (seg1_q),
    .seg2_q    (seg2_q),
    .jump_q    (jump_q),
    .restart   (restart),
    .adj       (adj)
);

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_i = 1'b1;
    logic [8:0] cfg_presc_i = '0;
    logic [7:0] cfg_seg1_i = '0;
    logic [6:0] cfg_seg2_i = '0;
    logic [6:0] cfg_jump_i = '0;
    logic       bus_idle_i = 1'b0;
    logic       rx_i = 1'b1;
    logic       tq_o, sample_o, rx_bit_o, bit_end_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    typedef struct {
        bit    kind;     // 0 = sample strobe, 1 = bit-end strobe
        int    at;
        string tag;
    } ev_t;
    ev_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    can_bit_timer u_can_bit_timer (
        .clk(clk), .rst_n(rst_n), .init_i(init_i),
        .cfg_presc_i(cfg_presc_i), .cfg_seg1_i(cfg_seg1_i),
        .cfg_seg2_i(cfg_seg2_i), .cfg_jump_i(cfg_jump_i),
        .bus_idle_i(bus_idle_i), .rx_i(rx_i),
        .tq_o(tq_o), .sample_o(sample_o), .rx_bit_o(rx_bit_o), .bit_end_o(bit_end_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic push_ev(input bit kind, input int at, input string tag);
        ev_t e;
        e.kind = kind; e.at = at; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Plain bit whose synchronization quantum starts at clock s
    task automatic push_bit(input int s, input int p, input int s1, input int s2, input string tag);
        push_ev(1'b0, s + p*(1+s1) - 1, tag);
        push_ev(1'b1, s + p*(1+s1+s2) - 1, tag);
    endtask

    task automatic take(input bit kind);
        ev_t e;
        n_checks++;
        if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected strobe: actual kind %0d at %0d expected none", kind, cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || e.at != cyc) begin
                n_fail++;
                $display("FAIL %s: actual kind %0d at %0d expected kind %0d at %0d",
                         e.tag, kind, cyc, e.kind, e.at);
            end
        end
    endtask

    // Monitor: strobes depend on registers only; sample mid-cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sample_o)  take(1'b0);
            if (bit_end_o) take(1'b1);
        end
    end

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic setup(input int presc, input int s1f, input int s2f, input int jf, input bit idle);
        @(negedge clk);
        init_i      = 1'b1;
        cfg_presc_i = 9'(presc);
        cfg_seg1_i  = 8'(s1f);
        cfg_seg2_i  = 7'(s2f);
        cfg_jump_i  = 7'(jf);
        bus_idle_i  = idle;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run(input int stop, input string tag);
        wait_cyc(stop);
        init_i = 1'b1;
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        check(!tq_o && !sample_o && !bit_end_o, "R1 quiet in init", tq_o, 0);
        exp_q.delete();
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired: actual %0d cycles expected fewer", WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : driver
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!tq_o && !sample_o && !bit_end_o, "R1 strobes after reset", sample_o, 0);
        check(rx_bit_o == 1'b1, "R1 rx_bit after reset", rx_bit_o, 1);

        // R3: 24-quantum bit, 75 percent sample point
        setup(0, 16, 5, 0, 1'b0);
        c0 = cyc; init_i = 1'b0;
        for (int k = 0; k < 3; k++) push_bit(c0 + 1 + 24*k, 1, 17, 6, "R3 24q bit");
        finish_run(c0 + 73, "R3 all strobes seen");

        // R2 and R6: divider of 3, restart on leaving init
        setup(2, 3, 2, 0, 1'b0);
        c0 = cyc; init_i = 1'b0;
        for (int k = 0; k < 2; k++) push_bit(c0 + 1 + 24*k, 3, 4, 3, "R2 prescaled bit");
        wait_cyc(c0 + 2);
        check(tq_o == 1'b0, "R2 mid-quantum tq", tq_o, 0);
        wait_cyc(c0 + 3);
        check(tq_o == 1'b1, "R6 first quantum ends on clock 3", tq_o, 1);
        finish_run(c0 + 49, "R2 all strobes seen");

        // R6: changes while running ignored, applied after next init
        setup(0, 4, 3, 0, 1'b0);
        c0 = cyc; init_i = 1'b0;
        for (int k = 0; k < 3; k++) push_bit(c0 + 1 + 10*k, 1, 5, 4, "R6 config frozen");
        wait_cyc(c0 + 3);
        cfg_presc_i = 9'd1; cfg_seg1_i = 8'd9; cfg_seg2_i = 7'd1;
        finish_run(c0 + 31, "R6 all strobes seen");
        repeat (2) @(negedge clk);
        c0 = cyc; init_i = 1'b0;
        push_bit(c0 + 1, 2, 10, 2, "R6 new config after init");
        finish_run(c0 + 28, "R6 new config strobes seen");

        // R5: captured bit value; R10: rising edge has no effect
        setup(0, 4, 3, 0, 1'b0);
        rx_i = 1'b0;
        repeat (3) @(negedge clk);
        c0 = cyc; init_i = 1'b0;
        push_bit(c0 + 1, 1, 5, 4, "R5 timing");
        push_bit(c0 + 11, 1, 5, 4, "R10 rising edge ignored");
        wait_cyc(c0 + 7);
        check(rx_bit_o == 1'b0, "R5 dominant sampled", rx_bit_o, 0);
        rx_i = 1'b1;
        wait_cyc(c0 + 15);
        check(rx_bit_o == 1'b0, "R5 held until next sample", rx_bit_o, 0);
        wait_cyc(c0 + 17);
        check(rx_bit_o == 1'b1, "R5 recessive sampled", rx_bit_o, 1);
        finish_run(c0 + 21, "R5 all strobes seen");

        // R8: lengthen first segment (capped and uncapped); R10: second edge ignored
        setup(0, 7, 3, 1, 1'b0);
        c0 = cyc; init_i = 1'b0;
        push_ev(1'b0, c0 + 11, "R8 capped lengthen");
        push_ev(1'b1, c0 + 15, "R8 capped lengthen");
        push_ev(1'b0, c0 + 25, "R8 one-quantum lengthen");
        push_ev(1'b1, c0 + 29, "R10 second edge ignored");
        push_bit(c0 + 30, 1, 8, 4, "R8 following bit");
        wait_cyc(c0 + 5);  rx_i = 1'b0;
        wait_cyc(c0 + 12); rx_i = 1'b1;
        wait_cyc(c0 + 16); rx_i = 1'b0;
        wait_cyc(c0 + 18); rx_i = 1'b1;
        wait_cyc(c0 + 20); rx_i = 1'b0;
        wait_cyc(c0 + 26); rx_i = 1'b1;
        finish_run(c0 + 43, "R8 all strobes seen");

        // R9: shorten second segment, then cut it at the edge
        setup(0, 3, 5, 1, 1'b0);
        c0 = cyc; init_i = 1'b0;
        push_ev(1'b0, c0 + 5,  "R9 timing");
        push_ev(1'b1, c0 + 9,  "R9 shortened by jump width");
        push_ev(1'b0, c0 + 14, "R9 timing");
        push_ev(1'b1, c0 + 19, "R9 cut at edge");
        push_bit(c0 + 20, 1, 4, 6, "R9 following bit");
        wait_cyc(c0 + 6);  rx_i = 1'b0;
        wait_cyc(c0 + 8);  rx_i = 1'b1;
        wait_cyc(c0 + 18); rx_i = 1'b0;
        wait_cyc(c0 + 20); rx_i = 1'b1;
        finish_run(c0 + 31, "R9 all strobes seen");

        // R7: hard sync in second then first segment
        setup(0, 3, 5, 1, 1'b1);
        c0 = cyc; init_i = 1'b0;
        push_ev(1'b0, c0 + 5,  "R7 timing");
        push_ev(1'b0, c0 + 13, "R7 restart from second segment");
        push_ev(1'b1, c0 + 19, "R7 restart from second segment");
        push_ev(1'b0, c0 + 27, "R7 restart drops pending sample");
        push_ev(1'b1, c0 + 33, "R7 restart drops pending sample");
        push_bit(c0 + 34, 1, 4, 6, "R7 following bit");
        wait_cyc(c0 + 7);  rx_i = 1'b0;
        wait_cyc(c0 + 10); rx_i = 1'b1;
        wait_cyc(c0 + 21); rx_i = 1'b0;
        wait_cyc(c0 + 24); rx_i = 1'b1;
        finish_run(c0 + 45, "R7 all strobes seen");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule